// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block turns motor drive requests into the four gate commands of a full H-bridge: high side of leg A, low side of leg A, high side of leg B and low side of leg B. A direction input picks which diagonal pair drives the load. An external enable pin can chop the bridge, and its active level is set by a polarity bit. An internal off-time chopper can also request a decay interval, and it says whether that interval should be fast or slow.

During decay the block can run synchronous rectification. With rectification on, fast decay drives the opposite diagonal and slow decay turns on both low-side devices. Rectification stops at zero current in active mode, or at the current limit in passive mode. When rectification is off, every gate stays low during decay and the body diodes carry the current. Sleep, undervoltage or over-temperature forces every gate low.

Every gate turns on only after its leg partner has been off for a programmable number of clocks. A change of direction blanks the whole bridge for that same interval.

Top module: `hb_gate_ctrl`

## Requirements
- R1: The bridge conducts while `enable_in` differs from `en_pol`, and it is chopped into decay while the two are equal.
- R2: In a decay caused by the enable pin, `xpwm_slow`=0 gives fast decay and `xpwm_slow`=1 gives slow decay. In `gate_o`, bit0 is the leg A high side, bit1 the leg A low side, bit2 the leg B high side and bit3 the leg B low side. Fast decay with `phase_in`=1 gives 4'b0110, fast decay with `phase_in`=0 gives 4'b1001, and slow decay gives 4'b1010.
- R3: While driving, `phase_in`=1 gives 4'b1001 (current from A to B) and `phase_in`=0 gives 4'b0110.
- R4: While the enable pin allows conduction, `chop_req`=1 starts a decay that is fast when `chop_fast`=1 and slow otherwise. A decay caused by the enable pin takes priority, and it follows `xpwm_slow` whatever the chopper requests.
- R5: With `rect_en`=0, every gate is low during any decay.
- R6: In active rectification (`rect_passive`=0), `zero_cur`=1 turns every gate low during decay, and `over_lim` has no effect. Neither detect affects a drive interval.
- R7: In passive rectification (`rect_passive`=1), `over_lim`=1 turns every gate low during decay, and `zero_cur` has no effect.
- R8: When `sleep_in`, `uvlo_in` or `tsd_in` is high, `gate_o` is 4'b0000 after the next clock edge, whatever the other inputs are.
- R9: The two gates of one leg are never high in the same cycle.
- R10: A gate rises only after both gates of its leg have been low for at least `DEAD_CYC` cycles. When one gate hands over to its partner, the gap is exactly `DEAD_CYC` cycles.
- R11: After a change of `phase_in`, all four gates are low for exactly `DEAD_CYC` cycles before the new pair turns on.
- R12: While `rst` is high, `gate_o` is 4'b0000 from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_in | input | 1 | Drive direction |
| enable_in | input | 1 | External enable / chop pin |
| en_pol | input | 1 | Level of enable_in that chops the bridge |
| xpwm_slow | input | 1 | Decay kind for a chop from the enable pin (1 = slow) |
| chop_req | input | 1 | Internal chopper requests a decay interval |
| chop_fast | input | 1 | Internal decay is fast when high |
| rect_en | input | 1 | Synchronous rectification on |
| rect_passive | input | 1 | 1 = passive mode, 0 = active mode |
| zero_cur | input | 1 | Load current has reached zero |
| over_lim | input | 1 | Reversed current has reached the limit |
| sleep_in | input | 1 | Sleep request |
| uvlo_in | input | 1 | Undervoltage fault |
| tsd_in | input | 1 | Thermal fault |
| gate_o | output | 4 | Gate commands {B low, B high, A low, A high} |

## Verification
The assertions assume that every input is synchronous to `clk` and that each input holds its value from one clock edge to the next. The bench meets this by changing inputs only on the falling edge. The direction check assumes that the sample taken during reset is a valid earlier value of `phase_in`, so the bench holds `phase_in` at a defined level through reset. Steady-state vectors are held for more than one dead-time interval before they are sampled. The hand-over and direction-change tests begin from a settled drive state, so the gaps they measure start from a known pair.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    BR_DRIVE = 2'd0,
    BR_FAST  = 2'd1,
    BR_SLOW  = 2'd2
  } br_mode_e;

  // gate bit positions: {B low, B high, A low, A high}
  localparam int GI_SRC_A = 0;
  localparam int GI_SNK_A = 1;
  localparam int GI_SRC_B = 2;
  localparam int GI_SNK_B = 3;

  function automatic logic [3:0] leg_pattern(input br_mode_e m, input logic ph);
    logic [3:0] p;
    case (m)
      BR_DRIVE: p = ph ? 4'b1001 : 4'b0110;
      BR_FAST:  p = ph ? 4'b0110 : 4'b1001;
      BR_SLOW:  p = 4'b1010;
      default:  p = 4'b0000;
    endcase
    return p;
  endfunction

  function automatic logic rect_cutoff(input logic passive, input logic zc, input logic ol);
    return passive ? ol : zc;
  endfunction

endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic       phase_in,
  input  logic       enable_in,
  input  logic       en_pol,
  input  logic       xpwm_slow,
  input  logic       chop_req,
  input  logic       chop_fast,
  input  logic       rect_en,
  input  logic       rect_passive,
  input  logic       zero_cur,
  input  logic       over_lim,
  input  logic       fault,
  output logic [3:0] req_o
);

  br_mode_e mode;
  logic     ext_chop;
  logic     cut;

  assign ext_chop = (enable_in == en_pol);
  assign cut      = rect_cutoff(rect_passive, zero_cur, over_lim);

  always_comb begin
    if (ext_chop)      mode = xpwm_slow ? BR_SLOW : BR_FAST;
    else if (chop_req) mode = chop_fast ? BR_FAST : BR_SLOW;
    else               mode = BR_DRIVE;

    if (fault)                    req_o = 4'b0000;
    else if (mode == BR_DRIVE)    req_o = leg_pattern(mode, phase_in);
    else if (!rect_en || cut)     req_o = 4'b0000;
    else                          req_o = leg_pattern(mode, phase_in);
  end

endmodule

// File: rtl/hb_phase_blank.sv
module hb_phase_blank #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic phase_in,
  output logic blank_o
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  logic          phase_q;
  logic [CW-1:0] blk_cnt;
  logic          flip;

  assign flip    = (phase_in != phase_q);
  assign blank_o = flip || (blk_cnt != '0);

  always_ff @(posedge clk) begin
    phase_q <= phase_in;
    if (rst)
      blk_cnt <= '0;
    else if (flip)
      blk_cnt <= CW'(DEAD_CYC - 1);
    else if (blk_cnt != '0)
      blk_cnt <= blk_cnt - 1'b1;
  end

endmodule

// File: rtl/hb_leg_dt.sv
module hb_leg_dt #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic want_src,
  input  logic want_snk,
  output logic src_o,
  output logic snk_o,
  output logic ready_o
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  logic [CW-1:0] idle_cnt;
  logic          both_off;
  logic          src_d, snk_d;

  assign both_off = !src_o && !snk_o;
  assign ready_o  = both_off && (({1'b0, idle_cnt} + 1'b1) >= (CW+1)'(DEAD_CYC));
  assign src_d    = want_src && !want_snk && (src_o || ready_o);
  assign snk_d    = want_snk && !want_src && (snk_o || ready_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o    <= 1'b0;
      snk_o    <= 1'b0;
      idle_cnt <= CW'(DEAD_CYC);
    end else begin
      src_o <= src_d;
      snk_o <= snk_d;
      if (!both_off)
        idle_cnt <= '0;
      else if (idle_cnt != CW'(DEAD_CYC))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_in,
  input  logic       enable_in,
  input  logic       en_pol,
  input  logic       xpwm_slow,
  input  logic       chop_req,
  input  logic       chop_fast,
  input  logic       rect_en,
  input  logic       rect_passive,
  input  logic       zero_cur,
  input  logic       over_lim,
  input  logic       sleep_in,
  input  logic       uvlo_in,
  input  logic       tsd_in,
  output logic [3:0] gate_o
);

  localparam int NLEG = 2;

  logic            fault;
  logic [3:0]      req_raw;
  logic [3:0]      req_m;
  logic            blank;
  logic [NLEG-1:0] leg_ready;

  assign fault = sleep_in | uvlo_in | tsd_in;

  hb_decode u_dec (
    .phase_in    (phase_in),
    .enable_in   (enable_in),
    .en_pol      (en_pol),
    .xpwm_slow   (xpwm_slow),
    .chop_req    (chop_req),
    .chop_fast   (chop_fast),
    .rect_en     (rect_en),
    .rect_passive(rect_passive),
    .zero_cur    (zero_cur),
    .over_lim    (over_lim),
    .fault       (fault),
    .req_o       (req_raw)
  );

  hb_phase_blank #(.DEAD_CYC(DEAD_CYC)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .phase_in(phase_in),
    .blank_o (blank)
  );

  assign req_m = blank ? 4'b0000 : req_raw;

  for (genvar l = 0; l < NLEG; l++) begin : g_leg
    hb_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst     (rst),
      .want_src(req_m[2*l]),
      .want_snk(req_m[2*l+1]),
      .src_o   (gate_o[2*l]),
      .snk_o   (gate_o[2*l+1]),
      .ready_o (leg_ready[l])
    );
  end

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int DEAD_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       phase_in,
  input logic       sleep_in,
  input logic       uvlo_in,
  input logic       tsd_in,
  input logic [3:0] gate_o
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  assert_leg_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]));

  assert_fault_off_R8: assert property (@(posedge clk) disable iff (rst)
    (sleep_in || uvlo_in || tsd_in) |=> (gate_o == 4'b0000));

  assert_phase_blank_R11: assert property (@(posedge clk) disable iff (rst)
    (phase_in != $past(phase_in)) |=> (gate_o == 4'b0000));

  assert_reset_off_R12: assert property (@(posedge clk)
    rst |=> (gate_o == 4'b0000));

  for (genvar l = 0; l < 2; l++) begin : g_dt
    logic [CW-1:0] low_cnt;
    always_ff @(posedge clk) begin
      if (rst)
        low_cnt <= CW'(DEAD_CYC);
      else if (gate_o[2*l] || gate_o[2*l+1])
        low_cnt <= '0;
      else if (low_cnt != CW'(DEAD_CYC))
        low_cnt <= low_cnt + 1'b1;
    end

    assert_src_gap_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_o[2*l]) |-> (low_cnt == CW'(DEAD_CYC)));

    assert_snk_gap_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_o[2*l+1]) |-> (low_cnt == CW'(DEAD_CYC)));
  end

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .phase_in(phase_in),
  .sleep_in(sleep_in),
  .uvlo_in (uvlo_in),
  .tsd_in  (tsd_in),
  .gate_o  (gate_o)
);

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;

  localparam int DT = 4;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_in = 1'b1, enable_in = 1'b1, en_pol = 1'b0, xpwm_slow = 1'b0;
  logic chop_req = 1'b0, chop_fast = 1'b0, rect_en = 1'b1, rect_passive = 1'b0;
  logic zero_cur = 1'b0, over_lim = 1'b0, sleep_in = 1'b0, uvlo_in = 1'b0, tsd_in = 1'b0;
  logic [3:0] gate_o;

  int n_chk = 0;
  int n_bad = 0;
  int leg_clash = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.DEAD_CYC(DT)) u_hb_gate_ctrl (
    .clk(clk), .rst(rst), .phase_in(phase_in), .enable_in(enable_in), .en_pol(en_pol),
    .xpwm_slow(xpwm_slow), .chop_req(chop_req), .chop_fast(chop_fast), .rect_en(rect_en),
    .rect_passive(rect_passive), .zero_cur(zero_cur), .over_lim(over_lim),
    .sleep_in(sleep_in), .uvlo_in(uvlo_in), .tsd_in(tsd_in), .gate_o(gate_o)
  );

  // {req id[3:0], phase, en, pol, xslow, chop, cfast, rect_en, passive, zc, ol, sleep, uv, tsd, expected[3:0]}
  localparam logic [20:0] TBL [NV] = '{
    {4'd1,  13'b1100_0010_0000_0, 4'b1001},  // R1 drive, pin differs from polarity
    {4'd3,  13'b0100_0010_0000_0, 4'b0110},  // R3 reverse direction
    {4'd1,  13'b1010_0010_0000_0, 4'b1001},  // R1 inverted polarity still drives
    {4'd2,  13'b1110_0010_0000_0, 4'b0110},  // R2 pin chop, fast decay
    {4'd2,  13'b1111_0010_0000_0, 4'b1010},  // R2 pin chop, slow decay
    {4'd4,  13'b0100_1110_0000_0, 4'b1001},  // R4 chopper fast, phase 0
    {4'd4,  13'b0100_1010_0000_0, 4'b1010},  // R4 chopper slow
    {4'd5,  13'b0100_1000_0000_0, 4'b0000},  // R5 chopper decay, no rectification
    {4'd5,  13'b1001_0000_0000_0, 4'b0000},  // R5 pin decay, no rectification
    {4'd6,  13'b1001_0010_1000_0, 4'b0000},  // R6 active mode zero current
    {4'd6,  13'b1001_0010_0100_0, 4'b1010},  // R6 active mode ignores limit
    {4'd7,  13'b1001_0011_0100_0, 4'b0000},  // R7 passive mode limit
    {4'd7,  13'b1000_0011_1000_0, 4'b0110},  // R7 passive mode ignores zero current
    {4'd6,  13'b1100_0010_1100_0, 4'b1001},  // R6 detects ignored while driving
    {4'd8,  13'b1100_0010_0010_0, 4'b0000},  // R8 sleep
    {4'd8,  13'b1100_0010_0001_0, 4'b0000},  // R8 undervoltage
    {4'd8,  13'b1100_0010_0000_1, 4'b0000},  // R8 thermal
    {4'd4,  13'b1111_1110_0000_0, 4'b1010}   // R4 pin chop beats chopper
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gate_o actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] v);
    {phase_in, enable_in, en_pol, xpwm_slow, chop_req, chop_fast, rect_en,
     rect_passive, zero_cur, over_lim, sleep_in, uvlo_in, tsd_in} = v;
  endtask

  task automatic settle_drive_ph1();
    @(negedge clk);
    apply(13'b1100_0010_0000_0);
    repeat (DT + 4) @(negedge clk);
  endtask

  always @(negedge clk)
    if (!rst && ((gate_o[0] && gate_o[1]) || (gate_o[2] && gate_o[3]))) leg_clash++;

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12 reset", gate_o, 4'b0000);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i][16:4]);
      repeat (DT + 4) @(negedge clk);
      check($sformatf("R%0d vector %0d", TBL[i][20:17], i), gate_o, TBL[i][3:0]);
    end

    // R11 direction change gap
    settle_drive_ph1();
    phase_in = 1'b0;
    begin
      int gap = 0;
      @(negedge clk);
      while (gate_o == 4'b0000 && gap < 50) begin
        gap++;
        @(negedge clk);
      end
      check("R11 gap length", 4'(gap), 4'(DT));
      check("R11 new pair", gate_o, 4'b0110);
    end

    // R10 hand-over in leg A while leg B low side stays on
    settle_drive_ph1();
    enable_in = 1'b0; xpwm_slow = 1'b1;
    begin
      int gap = 0;
      bit b_held = 1'b1;
      @(negedge clk);
      while (gate_o[1:0] == 2'b00 && gap < 50) begin
        gap++;
        if (!gate_o[3]) b_held = 1'b0;
        @(negedge clk);
      end
      check("R10 leg A gap", 4'(gap), 4'(DT));
      check("R10 leg B low side held", {3'b000, b_held}, 4'b0001);
      check("R10 slow pattern", gate_o, 4'b1010);
    end

    // R8 one-edge response
    settle_drive_ph1();
    tsd_in = 1'b1;
    @(negedge clk);
    check("R8 thermal next edge", gate_o, 4'b0000);
    tsd_in = 1'b0; uvlo_in = 1'b1;
    repeat (DT + 2) @(negedge clk);
    check("R8 undervoltage held", gate_o, 4'b0000);
    uvlo_in = 1'b0;
    repeat (DT + 2) @(negedge clk);
    check("R3 recovery drive", gate_o, 4'b1001);

    // R12 reset mid-drive
    rst = 1'b1;
    @(negedge clk);
    check("R12 reset while driving", gate_o, 4'b0000);
    rst = 1'b0;

    // R9 leg exclusivity over the whole run
    check("R9 leg clash count", 4'(leg_clash), 4'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    finished = 1'b1;
    $finish;
  end

endmodule